// File: doc/BRIEF.md
# PWM Interrupt Status Unit

This block collects the interrupt sources of a two-output PWM generator into one status byte and one enable byte. It watches the two PWM outputs and latches a flag on any level change, so software can spot an output that has stopped toggling. It latches the event reports of two retrigger/fault channels. At each event it also records which of the four ramps of the PWM cycle was running.

A cycle-position flag is set either at the end of every PWM cycle, or only at the end of the 15th cycle of a 16-cycle enhanced sequence. The enhanced case leaves software time to load new values before the next sequence starts. Software reads both bytes and clears status flags by writing ones. A single request line combines every flag with its enable.

The PWM counter, waveform generation and event filtering sit outside this block. They arrive here as single-cycle strobes in the block's clock domain.

Top module: `pwm_irq_status`

## Requirements
- R1: After reset, the status byte, the enable byte and `irq_o` are all zero.
- R2: Status bit 6 (output A activity) is set one clock edge after `pwm_a_i` differs from its value at the previous edge, on rising and on falling changes. Status bit 7 does the same for `pwm_b_i`.
- R3: Writing the status byte (`addr_i`=0) clears each flag in bits 7, 6, 4, 3 and 0 whose written bit is one. Flags whose written bit is zero keep their value.
- R4: A pulse on `evt_a_i` sets status bit 3, and a pulse on `evt_b_i` sets status bit 4, whatever the enable byte holds.
- R5: Status bits 2:1 load `ramp_i` on every clock edge where `evt_a_i` or `evt_b_i` is high, and hold that value otherwise. Software writes to these bits have no effect.
- R6: When enable bit 1 (enhanced select) is zero, a pulse on `cycle_end_i` sets status bit 0.
- R7: When enable bit 1 is one, only a pulse on `enh_end_i` sets status bit 0, and `cycle_end_i` is ignored.
- R8: `irq_o` is high exactly when a set status flag has its enable set. Enable bits 7, 6, 4 and 3 gate the flags at the same positions. Status bit 0 is gated by enable bit 0 OR enable bit 1.
- R9: If a hardware set and a write-one-to-clear hit the same flag on the same edge, the flag ends up set.
- R10: Status bit 5 always reads zero. In the enable byte (`addr_i`=1), only bits 7, 6, 4, 3, 1 and 0 store data, and the other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_a_i | input | 1 | PWM output A level |
| pwm_b_i | input | 1 | PWM output B level |
| evt_a_i | input | 1 | Event strobe, retrigger/fault channel A |
| evt_b_i | input | 1 | Event strobe, retrigger/fault channel B |
| ramp_i | input | 2 | Index of the ramp currently running |
| cycle_end_i | input | 1 | Strobe at the end of each PWM cycle |
| enh_end_i | input | 1 | Strobe at the end of the 15th cycle of an enhanced sequence |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 status, 1 enable |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the selected register, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every flag, the ramp field and the enable byte change on the first rising edge after their input is presented. Read data and `irq_o` follow that edge combinationally with no further delay. The bench therefore drives each stimulus on a falling edge, removes strobes on the next falling edge, and samples on that same falling edge, one edge after the stimulus. The same-edge set-versus-clear case and the ignored strobes are both observed on the falling edge that follows the edge where they could have taken effect.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;
  localparam int REG_W   = 8;
  localparam int RAMP_W  = 2;
  localparam int NUM_CH  = 2;
  // status byte positions
  localparam int S_EOC   = 0;
  localparam int S_RAMP  = 1;
  localparam int S_EVA   = 3;
  localparam int S_EVB   = 4;
  localparam int S_ACTA  = 6;
  localparam int S_ACTB  = 7;
  // enable byte positions
  localparam int E_EOC   = 0;
  localparam int E_ENH   = 1;
  localparam logic [REG_W-1:0] EN_MASK = 8'hDB;
  localparam int NUM_FLG = 5;
endpackage

// File: rtl/pwm_irq_flag.sv
module pwm_irq_flag #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~clr_i) | set_i;
  end
  assign q_o = q_q;
endmodule

// File: rtl/pwm_irq_activity.sv
module pwm_irq_activity #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pwm_i,
  output logic [NCH-1:0] tog_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= pwm_i[c];
    end
    assign tog_o[c] = pwm_i[c] ^ prev_q;
  end
endmodule

// File: rtl/pwm_irq_ramp.sv
module pwm_irq_ramp #(
  parameter int RW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [RW-1:0] ramp_i,
  output logic [RW-1:0] ramp_o
);
  logic [RW-1:0] ramp_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ramp_q <= '0;
    else if (cap_i) ramp_q <= ramp_i;
  end
  assign ramp_o = ramp_q;
endmodule

// File: rtl/pwm_irq_status.sv
module pwm_irq_status
  import pwm_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_a_i,
  input  logic              pwm_b_i,
  input  logic              evt_a_i,
  input  logic              evt_b_i,
  input  logic [RAMP_W-1:0] ramp_i,
  input  logic              cycle_end_i,
  input  logic              enh_end_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0]  tog;
  logic [NUM_FLG-1:0] flg_set, flg_clr, flg, flg_en;
  logic [RAMP_W-1:0]  ramp_q;
  logic [REG_W-1:0]   en_q, stat_vec;
  logic               wr_stat, wr_en_reg, cyc_set;

  assign wr_stat   = wr_en_i & ~addr_i;
  assign wr_en_reg = wr_en_i &  addr_i;

  pwm_irq_activity #(.NCH(NUM_CH)) u_act (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pwm_i ({pwm_b_i, pwm_a_i}),
    .tog_o (tog)
  );

  pwm_irq_ramp #(.RW(RAMP_W)) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (evt_a_i | evt_b_i),
    .ramp_i(ramp_i),
    .ramp_o(ramp_q)
  );

  // enhanced select picks the 15th-cycle strobe instead of every cycle end
  assign cyc_set = en_q[E_ENH] ? enh_end_i : cycle_end_i;

  // flag order: {act_b, act_a, ev_b, ev_a, eoc}
  assign flg_set = {tog[1], tog[0], evt_b_i, evt_a_i, cyc_set};
  assign flg_clr = wr_stat ? {wr_data_i[S_ACTB], wr_data_i[S_ACTA],
                              wr_data_i[S_EVB],  wr_data_i[S_EVA],
                              wr_data_i[S_EOC]} : '0;

  pwm_irq_flag #(.W(NUM_FLG)) u_flg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flg_set),
    .clr_i (flg_clr),
    .q_o   (flg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_en_reg) en_q <= wr_data_i & EN_MASK;
  end

  always_comb begin
    stat_vec                        = '0;
    stat_vec[S_EOC]                 = flg[0];
    stat_vec[S_RAMP +: RAMP_W]      = ramp_q;
    stat_vec[S_EVA]                 = flg[1];
    stat_vec[S_EVB]                 = flg[2];
    stat_vec[S_ACTA]                = flg[3];
    stat_vec[S_ACTB]                = flg[4];
  end

  assign flg_en = {en_q[S_ACTB], en_q[S_ACTA], en_q[S_EVB], en_q[S_EVA],
                   en_q[E_EOC] | en_q[E_ENH]};

  assign irq_o     = |(flg & flg_en);
  assign rd_data_o = addr_i ? en_q : stat_vec;
endmodule

// File: rtl/pwm_irq_status_chk.sv
module pwm_irq_status_chk
  import pwm_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwm_a_i,
  input logic              evt_a_i,
  input logic              evt_b_i,
  input logic [RAMP_W-1:0] ramp_i,
  input logic              cycle_end_i,
  input logic              enh_end_i,
  input logic              wr_en_i,
  input logic              addr_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [REG_W-1:0]  stat_i,
  input logic [REG_W-1:0]  en_i,
  input logic              irq_o
);
  assert_act_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && pwm_a_i != $past(pwm_a_i)) |=> stat_i[S_ACTA]);

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wr_data_i[S_EVA] && !evt_a_i) |=> !stat_i[S_EVA]);

  assert_evt_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_b_i |=> stat_i[S_EVB]);

  assert_ramp_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_a_i || evt_b_i) |=> stat_i[S_RAMP +: RAMP_W] == $past(ramp_i));

  assert_ramp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_a_i || evt_b_i) |=> $stable(stat_i[S_RAMP +: RAMP_W]));

  assert_enh_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i[E_ENH] && !wr_en_i && cycle_end_i && !enh_end_i && !stat_i[S_EOC])
    |=> !stat_i[S_EOC]);

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_i != '0 && stat_i != '0));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_a_i && wr_en_i && !addr_i && wr_data_i[S_EVA]) |=> stat_i[S_EVA]);
endmodule

bind pwm_irq_status pwm_irq_status_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwm_a_i    (pwm_a_i),
  .evt_a_i    (evt_a_i),
  .evt_b_i    (evt_b_i),
  .ramp_i     (ramp_i),
  .cycle_end_i(cycle_end_i),
  .enh_end_i  (enh_end_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wr_data_i  (wr_data_i),
  .stat_i     (stat_vec),
  .en_i       (en_q),
  .irq_o      (irq_o)
);

// File: tb/pwm_irq_status_test.sv
module pwm_irq_status_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwm_a_i = 0, pwm_b_i = 0, evt_a_i = 0, evt_b_i = 0;
  logic [1:0] ramp_i = 0;
  logic       cycle_end_i = 0, enh_end_i = 0, wr_en_i = 0, addr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [7:0] rd_data_o;
  logic       irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  pwm_irq_status uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk_i); endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en_i = 1; addr_i = a; wr_data_i = d; tick; wr_en_i = 0; wr_data_i = 0;
  endtask

  task automatic clear_all;
    wr(1'b0, 8'hFF); wr(1'b1, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); check("R1 status", d, 8'h00);
    rd(1, d); check("R1 enable", d, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_activity;
    logic [7:0] d;
    pwm_a_i = 1; tick; rd(0, d); check("R2 rise A", d & 8'hC0, 8'h40);
    wr(0, 8'h40); rd(0, d); check("R3 clear act A", d & 8'hC0, 8'h00);
    pwm_a_i = 0; tick; rd(0, d); check("R2 fall A", d & 8'hC0, 8'h40);
    pwm_b_i = 1; tick; rd(0, d); check("R2 rise B", d & 8'hC0, 8'hC0);
    tick; wr(0, 8'hC0); rd(0, d); check("R2 steady no set", d & 8'hC0, 8'h00);
    pwm_b_i = 0; tick; clear_all;
  endtask

  task automatic t_event_w1c;
    logic [7:0] d;
    evt_a_i = 1; evt_b_i = 1; tick; evt_a_i = 0; evt_b_i = 0;
    rd(0, d); check("R4 events set, enables off", d & 8'h18, 8'h18);
    check("R8 no irq when disabled", {7'd0, irq_o}, 8'h00);
    wr(0, 8'h00); rd(0, d); check("R3 write zero keeps", d & 8'h18, 8'h18);
    wr(0, 8'h08); rd(0, d); check("R3 clear only A", d & 8'h18, 8'h10);
    clear_all;
  endtask

  task automatic t_ramp;
    logic [7:0] d;
    ramp_i = 2'd2; evt_b_i = 1; tick; evt_b_i = 0;
    ramp_i = 2'd3; tick;
    rd(0, d); check("R5 ramp captured and held", d & 8'h06, 8'h04);
    wr(0, 8'h06); rd(0, d); check("R5 ramp write ignored", d & 8'h06, 8'h04);
    ramp_i = 2'd1; evt_a_i = 1; tick; evt_a_i = 0;
    rd(0, d); check("R5 ramp on event A", d & 8'h06, 8'h02);
    clear_all;
  endtask

  task automatic t_cycle;
    logic [7:0] d;
    wr(1, 8'h01);
    cycle_end_i = 1; tick; cycle_end_i = 0;
    rd(0, d); check("R6 cycle end flag", d & 8'h01, 8'h01);
    check("R8 irq from eoc", {7'd0, irq_o}, 8'h01);
    wr(0, 8'h01); check("R8 irq drops after clear", {7'd0, irq_o}, 8'h00);
    wr(1, 8'h02);
    cycle_end_i = 1; tick; cycle_end_i = 0;
    rd(0, d); check("R7 cycle end ignored", d & 8'h01, 8'h00);
    enh_end_i = 1; tick; enh_end_i = 0;
    rd(0, d); check("R7 enhanced end flag", d & 8'h01, 8'h01);
    check("R8 irq via enhanced enable", {7'd0, irq_o}, 8'h01);
    clear_all;
  endtask

  task automatic t_race;
    logic [7:0] d;
    evt_a_i = 1; wr_en_i = 1; addr_i = 0; wr_data_i = 8'h08; tick;
    evt_a_i = 0; wr_en_i = 0; wr_data_i = 0;
    rd(0, d); check("R9 set beats clear", d & 8'h08, 8'h08);
    wr(1, 8'h08); check("R8 irq event A", {7'd0, irq_o}, 8'h01);
    wr(1, 8'h10); check("R8 other enable no irq", {7'd0, irq_o}, 8'h00);
    clear_all;
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(1, 8'hFF); rd(1, d); check("R10 enable mask", d, 8'hDB);
    wr(0, 8'h20); rd(0, d); check("R10 bit5 zero", d & 8'h20, 8'h00);
    clear_all;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick; tick; t_reset;
    rst_ni = 1; tick; tick;
    t_reset;
    t_activity;
    t_event_w1c;
    t_ramp;
    t_cycle;
    t_race;
    t_reserved;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule